// File: doc/BRIEF.md
# Thread Context Parking Store

This block holds thread contexts that have been pushed out of a core and are waiting to be resumed somewhere else. Each parked thread owns one fixed slot, chosen by the hardware thread number that the migration fabric gives it. That number is unrelated to any operating-system thread number. The store attaches to the thread interconnect like a core does: packets come in through an input buffer and leave through an output buffer.

On ingress, a packet is a sequence of flits: a header, an ID flit, zero or more body flits that each carry a data word and a label, and a tail. The ingress machine has four states: WAIT_HEAD, WAIT_ID, BODY and DISCARD. A header moves it from WAIT_HEAD to WAIT_ID. An ID flit moves it from WAIT_ID to BODY when the target slot is empty, or to DISCARD when the slot already holds a context. In either BODY or DISCARD, a tail returns it to WAIT_HEAD. A tail arriving in WAIT_ID also returns it to WAIT_HEAD. Body flits are written into the slot in arrival order, and the tail sets the slot's presence bit together with its stored word count.

On egress, a migrate-out command names a slot and a destination. The egress machine has five states: IDLE, HEAD, ID, BODY and TAIL. An accepted command moves it from IDLE to HEAD. Each flit the output buffer takes moves it one state forward: HEAD to ID, ID to BODY (or straight to TAIL when the slot is empty of words), BODY to TAIL after the last stored word, and TAIL back to IDLE. A command for an absent slot leaves it in IDLE. The presence bit is cleared when the tail is taken.

Top module: `ctx_store`

## Requirements
- R1: After reset no slot is present (`slot_valid` is all zero), `out_valid` is low and `cmd_ready` is high.
- R2: Flit kinds are encoded 0 = header, 1 = ID, 2 = body, 3 = tail. The slot number is taken from the low `$clog2(MAX_THREADS)` bits of the ID flit's data. After the tail of a packet to an empty slot has been consumed, that slot's bit in `slot_valid` is set, and the body words and their labels are kept in arrival order.
- R3: An ID flit naming a slot that is already present causes `err_overwrite` to pulse for one cycle. The rest of that packet is discarded, and the slot's stored words, labels and count are left unchanged.
- R4: A migrate-out command for a slot that is not present causes `cmd_reject` to pulse for one cycle. No flit is emitted and `slot_valid` is unchanged.
- R5: A migrate-out command for a present slot causes `cmd_accept` to pulse. The block then emits a header (data = destination, zero-extended), then an ID flit (data = slot number), then the stored words with their original labels in stored order, and finally a tail. Header, ID and tail flits carry label 0.
- R6: The slot's presence bit stays set until the tail flit has been taken by the output buffer, including while the tail is held back by `out_ready` being low. It is clear after that transfer. While `out_ready` is low, the offered flit does not change.
- R7: Body flits beyond `SLOT_WORDS` are dropped, and `err_overflow` pulses for each dropped flit. The slot keeps exactly `SLOT_WORDS` words.
- R8: A packet with no body flits parks an empty context. Migrating that context out emits only a header, an ID flit and a tail.
- R9: While a packet is being emitted, `cmd_ready` is low and any command presented is ignored: there is no accept or reject pulse, and other slots keep their presence bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input buffer holds a flit |
| in_ready | output | 1 | Flit is consumed (always high) |
| in_kind | input | 2 | Flit kind of incoming flit |
| in_label | input | LABEL_W | Label of incoming body flit |
| in_data | input | DATA_W | Data of incoming flit |
| cmd_valid | input | 1 | Migrate-out command present |
| cmd_ready | output | 1 | Egress idle, command can be taken |
| cmd_slot | input | $clog2(MAX_THREADS) | Slot to migrate out |
| cmd_dest | input | DEST_W | Destination written into the header |
| cmd_accept | output | 1 | One-cycle pulse: command accepted |
| cmd_reject | output | 1 | One-cycle pulse: slot absent, command refused |
| out_valid | output | 1 | Outgoing flit offered |
| out_ready | input | 1 | Output buffer takes the flit |
| out_kind | output | 2 | Flit kind of outgoing flit |
| out_label | output | LABEL_W | Label of outgoing flit |
| out_data | output | DATA_W | Data of outgoing flit |
| slot_valid | output | MAX_THREADS | Presence bit per slot |
| err_overwrite | output | 1 | One-cycle pulse: packet for an occupied slot |
| err_overflow | output | 1 | One-cycle pulse: body flit beyond capacity dropped |

## Verification
Several results appear in the cycle after the clock edge that caused them. The accept and reject pulses follow the edge that sampled the command, and the two error pulses follow the edge that consumed the offending ID or body flit. The presence bit changes after the edge that consumed the tail, on both ingress and egress. The first outgoing flit is offered in the same cycle as the accept pulse. To match this, the bench drives every input on the falling edge and reads the pulses and `slot_valid` one time unit after the next rising edge. It records outgoing flits on the falling edge, when `out_valid` and `out_ready` are both high, so that each flit counts exactly once no matter how long it is stalled.

// File: rtl/ctx_store_pkg.sv
package ctx_store_pkg;

    typedef enum logic [1:0] {
        FLIT_HEAD = 2'd0,
        FLIT_ID   = 2'd1,
        FLIT_BODY = 2'd2,
        FLIT_TAIL = 2'd3
    } flit_kind_e;

    typedef enum logic [1:0] {
        IN_WAIT_HEAD,
        IN_WAIT_ID,
        IN_BODY,
        IN_DISCARD
    } in_state_e;

    typedef enum logic [2:0] {
        EG_IDLE,
        EG_HEAD,
        EG_ID,
        EG_BODY,
        EG_TAIL
    } eg_state_e;

endpackage

// File: rtl/ctx_ingress.sv
module ctx_ingress
    import ctx_store_pkg::*;
#(
    parameter int MAX_THREADS = 8,
    parameter int SLOT_WORDS  = 64,
    parameter int DATA_W      = 64,
    parameter int LABEL_W     = 8,
    localparam int ID_W  = $clog2(MAX_THREADS),
    localparam int IDX_W = $clog2(SLOT_WORDS),
    localparam int CNT_W = $clog2(SLOT_WORDS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             in_kind,
    input  logic [LABEL_W-1:0]     in_label,
    input  logic [DATA_W-1:0]      in_data,
    input  logic [MAX_THREADS-1:0] slot_valid,
    output logic                   wr_en,
    output logic [ID_W-1:0]        wr_slot,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [LABEL_W-1:0]     wr_label,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   fin_en,
    output logic [ID_W-1:0]        fin_slot,
    output logic [CNT_W-1:0]       fin_count,
    output logic                   err_overwrite,
    output logic                   err_overflow
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(SLOT_WORDS);

    in_state_e        state_q, state_d;
    logic [ID_W-1:0]  slot_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovw_q, ovf_q;

    flit_kind_e       kind;
    logic [ID_W-1:0]  pkt_id;
    logic             id_take, id_clash, body_take, body_room, tail_take;

    always_comb begin
        kind      = flit_kind_e'(in_kind);
        pkt_id    = in_data[ID_W-1:0];
        id_take   = in_valid && (state_q == IN_WAIT_ID) && (kind == FLIT_ID);
        id_clash  = id_take && slot_valid[pkt_id];
        body_room = (cnt_q < CAP);
        body_take = in_valid && (state_q == IN_BODY) && (kind == FLIT_BODY);
        tail_take = in_valid && (state_q == IN_BODY) && (kind == FLIT_TAIL);
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_WAIT_HEAD: if (in_valid && kind == FLIT_HEAD) state_d = IN_WAIT_ID;
            IN_WAIT_ID: begin
                if (id_take)                               state_d = id_clash ? IN_DISCARD : IN_BODY;
                else if (in_valid && kind == FLIT_TAIL)    state_d = IN_WAIT_HEAD;
            end
            IN_BODY:    if (tail_take)                     state_d = IN_WAIT_HEAD;
            IN_DISCARD: if (in_valid && kind == FLIT_TAIL) state_d = IN_WAIT_HEAD;
            default:                                       state_d = IN_WAIT_HEAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IN_WAIT_HEAD;
            slot_q  <= '0;
            cnt_q   <= '0;
            ovw_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ovw_q   <= id_clash;
            ovf_q   <= body_take && !body_room;
            if (id_take) begin
                slot_q <= pkt_id;
                cnt_q  <= '0;
            end else if (body_take && body_room) begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        wr_en         = body_take && body_room;
        wr_slot       = slot_q;
        wr_idx        = cnt_q[IDX_W-1:0];
        wr_label      = in_label;
        wr_data       = in_data;
        fin_en        = tail_take;
        fin_slot      = slot_q;
        fin_count     = cnt_q;
        err_overwrite = ovw_q;
        err_overflow  = ovf_q;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);

    // R3
    clash_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_clash |=> (state_q == IN_DISCARD) && err_overwrite);

endmodule

// File: rtl/ctx_slot_mem.sv
module ctx_slot_mem #(
    parameter int MAX_THREADS = 8,
    parameter int SLOT_WORDS  = 64,
    parameter int DATA_W      = 64,
    parameter int LABEL_W     = 8,
    localparam int ID_W   = $clog2(MAX_THREADS),
    localparam int IDX_W  = $clog2(SLOT_WORDS),
    localparam int CNT_W  = $clog2(SLOT_WORDS + 1),
    localparam int WORD_W = LABEL_W + DATA_W,
    localparam int DEPTH  = MAX_THREADS * SLOT_WORDS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ID_W-1:0]        wr_slot,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [WORD_W-1:0]      wr_word,
    input  logic                   fin_en,
    input  logic [ID_W-1:0]        fin_slot,
    input  logic [CNT_W-1:0]       fin_count,
    input  logic                   clr_en,
    input  logic [ID_W-1:0]        clr_slot,
    input  logic [ID_W-1:0]        rd_slot,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [WORD_W-1:0]      rd_word,
    output logic [CNT_W-1:0]       rd_count,
    output logic [MAX_THREADS-1:0] slot_valid
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [MAX_THREADS-1:0][CNT_W-1:0] cnt_all;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_slot, wr_idx}] <= wr_word;
    end

    for (genvar g = 0; g < MAX_THREADS; g++) begin : g_slot
        logic             v_q;
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                c_q <= '0;
            end else if (fin_en && fin_slot == ID_W'(g)) begin
                v_q <= 1'b1;
                c_q <= fin_count;
            end else if (clr_en && clr_slot == ID_W'(g)) begin
                v_q <= 1'b0;
            end
        end
        assign slot_valid[g] = v_q;
        assign cnt_all[g]    = c_q;
    end

    assign rd_word  = mem_q[{rd_slot, rd_idx}];
    assign rd_count = cnt_all[rd_slot];

    // R3
    no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_en |-> !slot_valid[fin_slot]);

    // R6
    clear_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> slot_valid[clr_slot]);

    // R3
    write_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !slot_valid[wr_slot]);

endmodule

// File: rtl/ctx_egress.sv
module ctx_egress
    import ctx_store_pkg::*;
#(
    parameter int MAX_THREADS = 8,
    parameter int SLOT_WORDS  = 64,
    parameter int DATA_W      = 64,
    parameter int LABEL_W     = 8,
    parameter int DEST_W      = 4,
    localparam int ID_W   = $clog2(MAX_THREADS),
    localparam int IDX_W  = $clog2(SLOT_WORDS),
    localparam int CNT_W  = $clog2(SLOT_WORDS + 1),
    localparam int WORD_W = LABEL_W + DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [ID_W-1:0]        cmd_slot,
    input  logic [DEST_W-1:0]      cmd_dest,
    output logic                   cmd_ready,
    output logic                   cmd_accept,
    output logic                   cmd_reject,
    input  logic [MAX_THREADS-1:0] slot_valid,
    output logic [ID_W-1:0]        rd_slot,
    output logic [IDX_W-1:0]       rd_idx,
    input  logic [WORD_W-1:0]      rd_word,
    input  logic [CNT_W-1:0]       rd_count,
    output logic                   clr_en,
    output logic [ID_W-1:0]        clr_slot,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [1:0]             out_kind,
    output logic [LABEL_W-1:0]     out_label,
    output logic [DATA_W-1:0]      out_data
);

    eg_state_e         state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [DEST_W-1:0] dest_q;
    logic [CNT_W-1:0]  idx_q;
    logic              acc_q, rej_q;
    logic              cmd_take, cmd_hit, last_word;

    always_comb begin
        cmd_take  = (state_q == EG_IDLE) && cmd_valid;
        cmd_hit   = slot_valid[cmd_slot];
        last_word = (idx_q + CNT_W'(1)) == rd_count;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EG_IDLE: if (cmd_take && cmd_hit)       state_d = EG_HEAD;
            EG_HEAD: if (out_ready)                 state_d = EG_ID;
            EG_ID:   if (out_ready)                 state_d = (rd_count == '0) ? EG_TAIL : EG_BODY;
            EG_BODY: if (out_ready && last_word)    state_d = EG_TAIL;
            EG_TAIL: if (out_ready)                 state_d = EG_IDLE;
            default:                                state_d = EG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EG_IDLE;
            id_q    <= '0;
            dest_q  <= '0;
            idx_q   <= '0;
            acc_q   <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            acc_q   <= cmd_take && cmd_hit;
            rej_q   <= cmd_take && !cmd_hit;
            if (cmd_take && cmd_hit) begin
                id_q   <= cmd_slot;
                dest_q <= cmd_dest;
            end
            if (state_q == EG_IDLE)                  idx_q <= '0;
            else if (state_q == EG_BODY && out_ready) idx_q <= idx_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_kind  = FLIT_HEAD;
        out_label = '0;
        out_data  = '0;
        unique case (state_q)
            EG_IDLE: ;
            EG_HEAD: begin
                out_valid = 1'b1;
                out_kind  = FLIT_HEAD;
                out_data  = DATA_W'(dest_q);
            end
            EG_ID: begin
                out_valid = 1'b1;
                out_kind  = FLIT_ID;
                out_data  = DATA_W'(id_q);
            end
            EG_BODY: begin
                out_valid = 1'b1;
                out_kind  = FLIT_BODY;
                out_label = rd_word[WORD_W-1:DATA_W];
                out_data  = rd_word[DATA_W-1:0];
            end
            EG_TAIL: begin
                out_valid = 1'b1;
                out_kind  = FLIT_TAIL;
            end
            default: ;
        endcase
        cmd_ready  = (state_q == EG_IDLE);
        cmd_accept = acc_q;
        cmd_reject = rej_q;
        rd_slot    = id_q;
        rd_idx     = idx_q[IDX_W-1:0];
        clr_en     = (state_q == EG_TAIL) && out_ready;
        clr_slot   = id_q;
    end

    // R6
    hold_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != EG_IDLE) |-> slot_valid[id_q]);

    // R6
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_kind)
                                      && $stable(out_data) && $stable(out_label));

    // R4
    reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> !out_valid);

endmodule

// File: rtl/ctx_store.sv
module ctx_store #(
    parameter int MAX_THREADS = 8,
    parameter int SLOT_WORDS  = 64,
    parameter int DATA_W      = 64,
    parameter int LABEL_W     = 8,
    parameter int DEST_W      = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [1:0]                     in_kind,
    input  logic [LABEL_W-1:0]             in_label,
    input  logic [DATA_W-1:0]              in_data,
    input  logic                           cmd_valid,
    output logic                           cmd_ready,
    input  logic [$clog2(MAX_THREADS)-1:0] cmd_slot,
    input  logic [DEST_W-1:0]              cmd_dest,
    output logic                           cmd_accept,
    output logic                           cmd_reject,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [1:0]                     out_kind,
    output logic [LABEL_W-1:0]             out_label,
    output logic [DATA_W-1:0]              out_data,
    output logic [MAX_THREADS-1:0]         slot_valid,
    output logic                           err_overwrite,
    output logic                           err_overflow
);

    localparam int ID_W   = $clog2(MAX_THREADS);
    localparam int IDX_W  = $clog2(SLOT_WORDS);
    localparam int CNT_W  = $clog2(SLOT_WORDS + 1);
    localparam int WORD_W = LABEL_W + DATA_W;

    logic               wr_en, fin_en, clr_en;
    logic [ID_W-1:0]    wr_slot, fin_slot, clr_slot, rd_slot;
    logic [IDX_W-1:0]   wr_idx, rd_idx;
    logic [LABEL_W-1:0] wr_label;
    logic [DATA_W-1:0]  wr_data;
    logic [CNT_W-1:0]   fin_count, rd_count;
    logic [WORD_W-1:0]  rd_word;

    assign in_ready = 1'b1;

    ctx_ingress #(
        .MAX_THREADS(MAX_THREADS), .SLOT_WORDS(SLOT_WORDS),
        .DATA_W(DATA_W), .LABEL_W(LABEL_W)
    ) u_ingress (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_kind(in_kind), .in_label(in_label), .in_data(in_data),
        .slot_valid(slot_valid),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
        .wr_label(wr_label), .wr_data(wr_data),
        .fin_en(fin_en), .fin_slot(fin_slot), .fin_count(fin_count),
        .err_overwrite(err_overwrite), .err_overflow(err_overflow)
    );

    ctx_slot_mem #(
        .MAX_THREADS(MAX_THREADS), .SLOT_WORDS(SLOT_WORDS),
        .DATA_W(DATA_W), .LABEL_W(LABEL_W)
    ) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
        .wr_word({wr_label, wr_data}),
        .fin_en(fin_en), .fin_slot(fin_slot), .fin_count(fin_count),
        .clr_en(clr_en), .clr_slot(clr_slot),
        .rd_slot(rd_slot), .rd_idx(rd_idx),
        .rd_word(rd_word), .rd_count(rd_count),
        .slot_valid(slot_valid)
    );

    ctx_egress #(
        .MAX_THREADS(MAX_THREADS), .SLOT_WORDS(SLOT_WORDS),
        .DATA_W(DATA_W), .LABEL_W(LABEL_W), .DEST_W(DEST_W)
    ) u_egress (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_slot(cmd_slot), .cmd_dest(cmd_dest),
        .cmd_ready(cmd_ready), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .slot_valid(slot_valid),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_word(rd_word), .rd_count(rd_count),
        .clr_en(clr_en), .clr_slot(clr_slot),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_label(out_label), .out_data(out_data)
    );

endmodule

// File: tb/ctx_store_tb_top.sv
module ctx_store_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;
    localparam int SW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'd0;
    logic [7:0]  in_label = '0;
    logic [63:0] in_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_slot = '0;
    logic [3:0]  cmd_dest = '0;
    logic        cmd_accept, cmd_reject;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_kind;
    logic [7:0]  out_label;
    logic [63:0] out_data;
    logic [7:0]  slot_valid;
    logic        err_overwrite, err_overflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_store dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_label(in_label), .in_data(in_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_slot(cmd_slot),
        .cmd_dest(cmd_dest), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_label(out_label), .out_data(out_data),
        .slot_valid(slot_valid),
        .err_overwrite(err_overwrite), .err_overflow(err_overflow)
    );

    // {slot, body words, seed, destination}
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0, 8'd5,  8'd11, 8'd3},
        {8'd3, 8'd1,  8'd22, 8'd9},
        {8'd7, 8'd64, 8'd33, 8'd15},
        {8'd5, 8'd0,  8'd44, 8'd1},
        {8'd2, 8'd70, 8'd55, 8'd6},
        {8'd6, 8'd17, 8'd66, 8'd0}
    };

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit saw_ovw, saw_ovf;

    logic [63:0] rdat [NT][SW];
    logic [7:0]  rlab [NT][SW];
    int          rcnt [NT];
    logic [7:0]  rvalid = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] gen_word(input int seed, input int i);
        return {32'(seed * 40503), 32'(i * 7 + 1)} ^ 64'h0F0F_1234_5678_0000;
    endfunction

    function automatic logic [7:0] gen_label(input int seed, input int i);
        return 8'(seed * 3 + i);
    endfunction

    task automatic send_flit(input logic [1:0] k, input logic [7:0] l, input logic [63:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_label = l; in_data = d;
        @(posedge clk);
        #1;
        saw_ovw |= err_overwrite;
        saw_ovf |= err_overflow;
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input int slot, input int n, input int seed, input int dest);
        bit was = rvalid[slot];
        saw_ovw = 1'b0;
        saw_ovf = 1'b0;
        send_flit(2'd0, 8'd0, 64'(dest));
        send_flit(2'd1, 8'd0, 64'(slot));
        for (int i = 0; i < n; i++) send_flit(2'd2, gen_label(seed, i), gen_word(seed, i));
        send_flit(2'd3, 8'd0, 64'd0);
        if (!was) begin
            rcnt[slot] = (n > SW) ? SW : n;
            for (int i = 0; i < rcnt[slot]; i++) begin
                rdat[slot][i] = gen_word(seed, i);
                rlab[slot][i] = gen_label(seed, i);
            end
            rvalid[slot] = 1'b1;
        end
        // R3 overwrite flag, R7 overflow flag, R2 presence after tail
        chk(saw_ovw == was, "R3", "overwrite flag", 64'(saw_ovw), 64'(was));
        chk(saw_ovf == (n > SW), "R7", "overflow flag", 64'(saw_ovf), 64'(n > SW));
        chk(slot_valid == rvalid, "R2", "presence after tail", 64'(slot_valid), 64'(rvalid));
    endtask

    task automatic migrate(input int slot, input int dest, input bit stall, input int other);
        bit ok = rvalid[slot];
        int n = rcnt[slot];
        int k = 0;
        int cyc = 0;
        int hold = 0;
        bit done = 1'b0;
        bit rdy;
        logic [1:0]  ek;
        logic [63:0] ed;
        logic [7:0]  el;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_slot = 3'(slot); cmd_dest = 4'(dest);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        if (!ok) begin
            chk(cmd_reject && !cmd_accept, "R4", "reject pulse", {cmd_accept, cmd_reject}, 64'd1);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(!out_valid, "R4", "no flit after reject", 64'(out_valid), 64'd0);
            end
            chk(slot_valid == rvalid, "R4", "presence unchanged", 64'(slot_valid), 64'(rvalid));
            return;
        end
        chk(cmd_accept && !cmd_reject, "R5", "accept pulse", {cmd_accept, cmd_reject}, 64'd2);
        while (!done) begin
            @(negedge clk);
            if (other >= 0) begin
                cmd_valid = 1'b1;
                cmd_slot  = 3'(other);
            end
            if (cyc == 0)
                chk(!cmd_ready, "R9", "busy during stream", 64'(cmd_ready), 64'd0);
            else
                chk(!cmd_accept && !cmd_reject, "R9", "command ignored while busy",
                    {cmd_accept, cmd_reject}, 64'd0);
            rdy = 1'b1;
            if (stall) begin
                if (out_valid && out_kind == 2'd3 && hold < 3) begin
                    rdy = 1'b0;
                    hold++;
                    chk(slot_valid[slot], "R6", "presence held under tail stall",
                        64'(slot_valid[slot]), 64'd1);
                end else if (out_kind != 2'd3) begin
                    rdy = ((cyc % 3) != 2);
                end
            end
            out_ready = rdy;
            if (out_valid && rdy) begin
                if (k == 0)          begin ek = 2'd0; ed = 64'(dest); el = 8'd0; end
                else if (k == 1)     begin ek = 2'd1; ed = 64'(slot); el = 8'd0; end
                else if (k < n + 2)  begin ek = 2'd2; ed = rdat[slot][k-2]; el = rlab[slot][k-2]; end
                else                 begin ek = 2'd3; ed = 64'd0; el = 8'd0; end
                chk(out_kind == ek && out_data == ed && out_label == el,
                    (n == 0) ? "R8" : "R5", $sformatf("flit %0d of slot %0d", k, slot),
                    {out_label, out_kind, out_data[53:0]}, {el, ek, ed[53:0]});
                if (k == n + 2) begin
                    done = 1'b1;
                    cmd_valid = 1'b0;
                end
                k++;
            end
            cyc++;
        end
        @(posedge clk);
        #1;
        out_ready = 1'b0;
        rvalid[slot] = 1'b0;
        chk(slot_valid == rvalid, "R6", "presence cleared after tail", 64'(slot_valid), 64'(rvalid));
        chk(!out_valid, "R5", "stream ended", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(slot_valid == 8'd0, "R1", "presence after reset", 64'(slot_valid), 64'd0);
        chk(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(cmd_ready, "R1", "cmd_ready after reset", 64'(cmd_ready), 64'd1);

        for (int i = 0; i < NVEC; i++)
            send_pkt(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));

        // R4 slot 1 never filled
        migrate(1, 2, 1'b0, -1);

        // R3 second packet to slot 4 is dropped
        send_pkt(4, 3, 90, 5);
        send_pkt(4, 4, 91, 5);

        for (int i = 0; i < NVEC; i++)
            migrate(int'(VEC[i][31:24]), int'(VEC[i][7:0]), (i % 2) == 1, (i == 0) ? 3 : -1);

        // R3 slot 4 still holds the first packet
        migrate(4, 12, 1'b1, -1);
        // R4 slot just emptied
        migrate(4, 12, 1'b0, -1);

        chk(slot_valid == 8'd0, "R6", "all slots released", 64'(slot_valid), 64'd0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule